// File: doc/BRIEF.md
# Class-Based Per-Flow Round-Robin Packet Scheduler

This block keeps track of packets that sit in a shared buffer and chooses which one leaves next. The buffer is carved into fixed slots. The scheduler owns the pool of free slots and the order in which filled slots are sent; the payload memory lives outside it. An enqueue request names a flow and a service class. The scheduler takes a slot from its free pool, reports the slot number so the caller can write the payload there, and links the slot onto that flow's packet chain. A dequeue request returns the flow and the slot that go out next, and the slot goes back to the free pool at once.

There are four service classes under strict priority, with class 0 the most urgent. Inside one class the flows that hold packets sit on a ring and take turns, one packet per turn. All bookkeeping is built from singly linked lists held in registers: one link array is shared between the per-flow packet chains and the free pool, and a second links the flows on each class ring. Every operation therefore takes a fixed, single cycle, no matter how many flows or packets are queued.

At most one operation is carried out per cycle. Each request is answered on the clock edge after the one that samples it.

Top module: `cfs_sched`

## Requirements
- R1: After reset every output is low, all classes are empty and the whole slot pool is free. Accepted enqueues then receive slots 0, 1, 2 and so on in ascending order.
- R2: An accepted enqueue raises `enq_ok` and returns the allocated slot on `enq_slot`. Free slots are handed out last-released-first: a slot freed by a dequeue is the next one allocated.
- R3: A dequeue always serves the lowest-numbered class that holds a packet. Class 0 has the highest priority and class 3 the lowest.
- R4: Flows within one class are served round-robin, one packet per turn. A flow that still holds packets after being served moves to the back of its class ring.
- R5: The packets of one flow leave in the order in which they were enqueued.
- R6: A flow's class is fixed by the packet that makes it active. Further packets for that flow join it in its stored class, whatever value `enq_class` carries.
- R7: A dequeue request while all classes are empty raises `deq_empty`, leaves `deq_valid` low and changes no state.
- R8: An enqueue request while no slot is free raises `enq_drop` and changes no state.
- R9: When enqueue and dequeue are requested in the same cycle, the dequeue is carried out and the enqueue is refused with `enq_drop`.
- R10: When a flow's last packet leaves, the flow is removed from its ring and becomes idle. Its next packet appends it again at the tail of the ring of the class given with that packet.
- R11: Each result appears exactly one cycle after its request. With no request, the result flags of that side stay low. `enq_ok` and `enq_drop` are never high together, and neither are `deq_valid` and `deq_empty`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_req | input | 1 | Request to queue one packet |
| enq_flow | input | $clog2(NUM_FLOWS) | Flow of the packet to queue |
| enq_class | input | 2 | Service class, 0 is the highest priority |
| deq_req | input | 1 | Request for the next packet to send |
| enq_ok | output | 1 | Enqueue accepted |
| enq_drop | output | 1 | Enqueue refused |
| enq_slot | output | $clog2(NUM_SLOTS) | Slot allocated to the accepted packet |
| deq_valid | output | 1 | A packet was selected |
| deq_empty | output | 1 | Dequeue found nothing queued |
| deq_flow | output | $clog2(NUM_FLOWS) | Flow of the selected packet |
| deq_slot | output | $clog2(NUM_SLOTS) | Slot of the selected packet, now free again |

## Verification
The hardest states to reach from the ports are a completely exhausted slot pool and a flow that drains, goes idle and comes back in another class while its old ring still holds other flows. The stimulus reaches the first by queuing one packet per free slot across many flows and classes, then pushing two more requests. It reaches the second by draining a single-packet flow and re-queuing it with a different class. A long random mix of enqueues, dequeues and collisions follows, in which the pool repeatedly fills and drains. A queue-based reference model predicts every output on every cycle.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    localparam int CLASS_CNT = 4;
    localparam int CLS_W     = 2;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_ENQ  = 2'd1,
        OP_DEQ  = 2'd2
    } op_e;

    typedef logic [CLS_W-1:0] cls_t;
endpackage

// File: rtl/cfs_slot_store.sv
module cfs_slot_store #(
    parameter int NUM_SLOTS = 32,
    localparam int SW = $clog2(NUM_SLOTS),
    localparam int CW = $clog2(NUM_SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  logic          release_en,
    input  logic [SW-1:0] rel_slot,
    input  logic          link_we,
    input  logic [SW-1:0] link_addr,
    input  logic [SW-1:0] link_data,
    input  logic [SW-1:0] rd_addr,
    output logic [SW-1:0] rd_next,
    output logic [SW-1:0] free_head,
    output logic          free_empty
);
    logic [SW-1:0] nxt [NUM_SLOTS];
    logic [CW-1:0] free_cnt;

    assign rd_next    = nxt[rd_addr];
    assign free_empty = (free_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                nxt[i] <= SW'(i + 1);
            end
            free_head <= '0;
            free_cnt  <= CW'(NUM_SLOTS);
        end else begin
            if (alloc) begin
                free_head <= nxt[free_head];
                free_cnt  <= free_cnt - 1'b1;
            end else if (release_en) begin
                nxt[rel_slot] <= free_head;
                free_head     <= rel_slot;
                free_cnt      <= free_cnt + 1'b1;
            end
            if (link_we) begin
                nxt[link_addr] <= link_data;
            end
        end
    end
endmodule

// File: rtl/cfs_class_rings.sv
module cfs_class_rings
    import cfs_pkg::*;
#(
    parameter int NUM_FLOWS = 16,
    localparam int FW = $clog2(NUM_FLOWS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic                          pop,
    input  logic                          rot,
    input  cls_t                          op_cls,
    input  logic [FW-1:0]                 push_flow,
    output logic [CLASS_CNT-1:0][FW-1:0]  ring_head,
    output logic [CLASS_CNT-1:0]          ring_ne
);
    logic [FW-1:0]                fnext [NUM_FLOWS];
    logic [CLASS_CNT-1:0][FW-1:0] hd_w;
    logic [CLASS_CNT-1:0][FW-1:0] tl_w;
    logic [CLASS_CNT-1:0]         ne_w;

    for (genvar c = 0; c < CLASS_CNT; c++) begin : g_cls
        logic [FW-1:0] hd;
        logic [FW-1:0] tl;
        logic          ne;
        logic          sel;

        assign sel     = (op_cls == CLS_W'(c));
        assign hd_w[c] = hd;
        assign tl_w[c] = tl;
        assign ne_w[c] = ne;

        always_ff @(posedge clk) begin
            if (rst) begin
                hd <= '0;
                tl <= '0;
                ne <= 1'b0;
            end else if (sel) begin
                if (push) begin
                    if (!ne) hd <= push_flow;
                    tl <= push_flow;
                    ne <= 1'b1;
                end else if (pop) begin
                    if (hd == tl) ne <= 1'b0;
                    else          hd <= fnext[hd];
                end else if (rot && (hd != tl)) begin
                    hd <= fnext[hd];
                    tl <= hd;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_FLOWS; i++) begin
                fnext[i] <= '0;
            end
        end else if (push && ne_w[op_cls]) begin
            fnext[tl_w[op_cls]] <= push_flow;
        end else if (rot && (hd_w[op_cls] != tl_w[op_cls])) begin
            fnext[tl_w[op_cls]] <= hd_w[op_cls];
        end
    end

    assign ring_head = hd_w;
    assign ring_ne   = ne_w;
endmodule

// File: rtl/cfs_prio_pick.sv
module cfs_prio_pick
    import cfs_pkg::*;
(
    input  logic [CLASS_CNT-1:0] ne,
    output cls_t                 sel,
    output logic                 any
);
    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = CLASS_CNT - 1; i >= 0; i--) begin
            if (ne[i]) begin
                sel = CLS_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfs_sched.sv
module cfs_sched
    import cfs_pkg::*;
#(
    parameter int NUM_FLOWS = 16,
    parameter int NUM_SLOTS = 32,
    localparam int FW = $clog2(NUM_FLOWS),
    localparam int SW = $clog2(NUM_SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enq_req,
    input  logic [FW-1:0] enq_flow,
    input  logic [1:0]    enq_class,
    input  logic          deq_req,
    output logic          enq_ok,
    output logic          enq_drop,
    output logic [SW-1:0] enq_slot,
    output logic          deq_valid,
    output logic          deq_empty,
    output logic [FW-1:0] deq_flow,
    output logic [SW-1:0] deq_slot
);
    typedef struct packed {
        logic [SW-1:0] head;
        logic [SW-1:0] tail;
        logic          sched;
        cls_t          cls;
    } flow_ent_t;

    flow_ent_t ftab [NUM_FLOWS];

    logic [CLASS_CNT-1:0][FW-1:0] ring_head;
    logic [CLASS_CNT-1:0]         class_ne;
    cls_t                         sel_cls;
    logic                         any_ne;
    logic [SW-1:0]                free_head;
    logic                         free_empty;
    logic [SW-1:0]                nxt_of_head;

    op_e           op;
    flow_ent_t     eq_ent;
    flow_ent_t     dq_ent;
    logic [FW-1:0] dq_flow;
    logic          dq_last;
    cls_t          op_cls;

    always_comb begin
        if (deq_req)                      op = any_ne ? OP_DEQ : OP_IDLE;
        else if (enq_req && !free_empty)  op = OP_ENQ;
        else                              op = OP_IDLE;
    end

    assign eq_ent  = ftab[enq_flow];
    assign dq_flow = ring_head[sel_cls];
    assign dq_ent  = ftab[dq_flow];
    assign dq_last = (dq_ent.head == dq_ent.tail);
    assign op_cls  = (op == OP_ENQ) ? cls_t'(enq_class) : dq_ent.cls;

    cfs_prio_pick u_pick (
        .ne  (class_ne),
        .sel (sel_cls),
        .any (any_ne)
    );

    cfs_slot_store #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .alloc      (op == OP_ENQ),
        .release_en (op == OP_DEQ),
        .rel_slot   (dq_ent.head),
        .link_we    ((op == OP_ENQ) && eq_ent.sched),
        .link_addr  (eq_ent.tail),
        .link_data  (free_head),
        .rd_addr    (dq_ent.head),
        .rd_next    (nxt_of_head),
        .free_head  (free_head),
        .free_empty (free_empty)
    );

    cfs_class_rings #(.NUM_FLOWS(NUM_FLOWS)) u_rings (
        .clk       (clk),
        .rst       (rst),
        .push      ((op == OP_ENQ) && !eq_ent.sched),
        .pop       ((op == OP_DEQ) && dq_last),
        .rot       ((op == OP_DEQ) && !dq_last),
        .op_cls    (op_cls),
        .push_flow (enq_flow),
        .ring_head (ring_head),
        .ring_ne   (class_ne)
    );

    // Flow state table
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_FLOWS; i++) begin
                ftab[i] <= '0;
            end
        end else begin
            case (op)
                OP_ENQ: begin
                    if (!eq_ent.sched) begin
                        ftab[enq_flow].head  <= free_head;
                        ftab[enq_flow].tail  <= free_head;
                        ftab[enq_flow].sched <= 1'b1;
                        ftab[enq_flow].cls   <= cls_t'(enq_class);
                    end else begin
                        ftab[enq_flow].tail  <= free_head;
                    end
                end
                OP_DEQ: begin
                    if (dq_last) ftab[dq_flow].sched <= 1'b0;
                    else         ftab[dq_flow].head  <= nxt_of_head;
                end
                default: ;
            endcase
        end
    end

    // Registered results
    always_ff @(posedge clk) begin
        if (rst) begin
            enq_ok    <= 1'b0;
            enq_drop  <= 1'b0;
            enq_slot  <= '0;
            deq_valid <= 1'b0;
            deq_empty <= 1'b0;
            deq_flow  <= '0;
            deq_slot  <= '0;
        end else begin
            enq_ok    <= (op == OP_ENQ);
            enq_drop  <= enq_req && (op != OP_ENQ);
            enq_slot  <= (op == OP_ENQ) ? free_head : '0;
            deq_valid <= (op == OP_DEQ);
            deq_empty <= deq_req && !any_ne;
            deq_flow  <= (op == OP_DEQ) ? dq_flow : '0;
            deq_slot  <= (op == OP_DEQ) ? dq_ent.head : '0;
        end
    end
endmodule

// File: rtl/cfs_sched_chk.sv
module cfs_sched_chk (
    input logic       clk,
    input logic       rst,
    input logic       enq_req,
    input logic       deq_req,
    input logic       enq_ok,
    input logic       enq_drop,
    input logic       deq_valid,
    input logic       deq_empty,
    input logic       free_empty,
    input logic [3:0] class_ne
);
    p_enq_answer_r11: assert property (@(posedge clk) disable iff (rst)
        enq_req |=> (enq_ok != enq_drop));

    p_enq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !enq_req |=> (!enq_ok && !enq_drop));

    p_deq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !deq_req |=> (!deq_valid && !deq_empty));

    p_drop_full_r8: assert property (@(posedge clk) disable iff (rst)
        (enq_req && !deq_req && free_empty) |=> enq_drop);

    p_collide_r9: assert property (@(posedge clk) disable iff (rst)
        (enq_req && deq_req) |=> enq_drop);

    p_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (deq_req && class_ne == 4'd0) |=> (deq_empty && !deq_valid));

    p_empty_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (deq_req && class_ne == 4'd0) |=> (class_ne == 4'd0));

    p_serve_r3: assert property (@(posedge clk) disable iff (rst)
        (deq_req && class_ne != 4'd0) |=> (deq_valid && !deq_empty));
endmodule

bind cfs_sched cfs_sched_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .enq_req    (enq_req),
    .deq_req    (deq_req),
    .enq_ok     (enq_ok),
    .enq_drop   (enq_drop),
    .deq_valid  (deq_valid),
    .deq_empty  (deq_empty),
    .free_empty (free_empty),
    .class_ne   (class_ne)
);

// File: tb/cfs_sched_tb.sv
`timescale 1ns/1ps
module cfs_sched_tb;
    localparam int NF = 16;
    localparam int NS = 32;
    localparam int FW = $clog2(NF);
    localparam int SW = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enq_req = 1'b0;
    logic [FW-1:0] enq_flow = '0;
    logic [1:0]    enq_class = '0;
    logic          deq_req = 1'b0;
    logic          enq_ok, enq_drop, deq_valid, deq_empty;
    logic [SW-1:0] enq_slot, deq_slot;
    logic [FW-1:0] deq_flow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state
    int fq [NF][$];
    int cq [4][$];
    int freeq [$];
    bit fsched [NF];

    always #10 clk = ~clk;

    cfs_sched u_dut (
        .clk(clk), .rst(rst),
        .enq_req(enq_req), .enq_flow(enq_flow), .enq_class(enq_class),
        .deq_req(deq_req),
        .enq_ok(enq_ok), .enq_drop(enq_drop), .enq_slot(enq_slot),
        .deq_valid(deq_valid), .deq_empty(deq_empty),
        .deq_flow(deq_flow), .deq_slot(deq_slot)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int f = 0; f < NF; f++) begin
            fq[f].delete();
            fsched[f] = 0;
        end
        for (int c = 0; c < 4; c++) cq[c].delete();
        freeq.delete();
        for (int s = 0; s < NS; s++) freeq.push_back(s);
    endtask

    // One request cycle: drive, predict, clock, compare.
    task automatic step(bit e, int f, int c, bit d, string tag);
        int x_eok, x_edrop, x_eslot, x_dv, x_de, x_df, x_ds, k, s;
        string etag, dtag;
        enq_req = e; enq_flow = FW'(f); enq_class = 2'(c); deq_req = d;
        x_eok = 0; x_edrop = 0; x_eslot = 0; x_dv = 0; x_de = 0; x_df = 0; x_ds = 0;
        etag = e ? tag : "R11";
        dtag = d ? tag : "R11";
        if (d) begin
            k = -1;
            for (int i = 3; i >= 0; i--) if (cq[i].size() > 0) k = i;
            if (k < 0) begin
                x_de = 1; dtag = "R7";
            end else begin
                x_dv = 1;
                x_df = cq[k].pop_front();
                x_ds = fq[x_df].pop_front();
                freeq.push_front(x_ds);
                if (fq[x_df].size() > 0) cq[k].push_back(x_df);
                else fsched[x_df] = 0;
            end
        end
        if (e) begin
            if (d) begin
                x_edrop = 1; etag = "R9";
            end else if (freeq.size() == 0) begin
                x_edrop = 1; etag = "R8";
            end else begin
                s = freeq.pop_front();
                x_eok = 1; x_eslot = s;
                fq[f].push_back(s);
                if (!fsched[f]) begin
                    fsched[f] = 1;
                    cq[c].push_back(f);
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(etag, "enq_ok", int'(enq_ok), x_eok);
        chk(etag, "enq_drop", int'(enq_drop), x_edrop);
        chk(etag, "enq_slot", int'(enq_slot), x_eslot);
        chk(dtag, "deq_valid", int'(deq_valid), x_dv);
        chk(dtag, "deq_empty", int'(deq_empty), x_de);
        chk(dtag, "deq_flow", int'(deq_flow), x_df);
        chk(dtag, "deq_slot", int'(deq_slot), x_ds);
        enq_req = 0; deq_req = 0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state visible at the outputs
        chk("R1", "enq_ok", int'(enq_ok), 0);
        chk("R1", "enq_drop", int'(enq_drop), 0);
        chk("R1", "deq_valid", int'(deq_valid), 0);
        chk("R1", "deq_empty", int'(deq_empty), 0);
        step(0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, "R11");
        // R1 / R2: ascending slots; R3 / R4 / R5 ordering
        step(1, 3, 2, 0, "R1");
        step(1, 5, 2, 0, "R1");
        step(1, 5, 2, 0, "R5");
        step(1, 3, 2, 0, "R5");
        step(1, 7, 1, 0, "R2");
        step(1, 9, 3, 0, "R2");
        step(0, 0, 0, 1, "R3");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, "R4");
        step(0, 0, 0, 1, "R3");
        step(0, 0, 0, 1, "R7");
        // R6: class fixed by the activating packet
        step(1, 2, 0, 0, "R6");
        step(1, 4, 1, 0, "R6");
        step(1, 2, 3, 0, "R6");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R6");
        // R10: drain, go idle, re-enter in another class behind others
        step(1, 8, 3, 0, "R10");
        step(1, 6, 3, 0, "R10");
        step(1, 6, 3, 0, "R10");
        step(0, 0, 0, 1, "R10");
        step(0, 0, 0, 1, "R10");
        step(1, 8, 0, 0, "R10");
        step(1, 10, 3, 0, "R10");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, "R10");
        // R8: exhaust the pool, then R2 reuse of the released slot
        for (int i = 0; i < NS; i++) step(1, i % NF, i % 4, 0, "R2");
        step(1, 1, 1, 0, "R8");
        step(1, 12, 0, 0, "R8");
        step(0, 0, 0, 1, "R3");
        step(1, 11, 2, 0, "R2");
        step(1, 11, 2, 0, "R8");
        // R9: collision
        step(1, 4, 0, 1, "R9");
        step(1, 4, 0, 1, "R9");
        for (int i = 0; i < NS + 2; i++) step(0, 0, 0, 1, "R4");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 8);
            step(r < 4 || r == 7, int'($urandom % NF), int'($urandom % 4),
                 r >= 4, "R3");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule